// File: doc/BRIEF.md
# Serial Display-Memory and Command Front End

This block is the host-facing slave port of a small segment-display controller. The host frames each transfer with an active-low select line. Bits reach the block on a single data line, and they are taken on the rising edge of a write strobe. Display nibbles go back to the host on the falling edge of a read strobe. Every frame opens with a three-bit mode code, sent first bit first. Code 110 reads from the display memory, code 101 writes to it or does a read-modify-write, and code 100 carries configuration commands. Any other code makes the block ignore the rest of the frame.

The display memory holds 64 four-bit words. A data frame gives a six-bit start address, most significant bit first. Nibbles follow, least significant bit first, and the address steps forward after each nibble. A command frame carries nine-bit codes, most significant bit first. Several codes may follow one mode code. Each recognised code raises one strobe for one clock, and the layout command also updates the registered commons and bias outputs.

All pins are sampled in the system-clock domain through a synchroniser, with edge detection after it. The host clocks every bit, so there is no valid/ready handshake and no back-pressure. The host must space its strobe edges far enough apart for the synchroniser to see each one.

Top module: `lcd_ser_front`

## Requirements
- R1: While `cs_n_i` is high, no transfer takes place and the frame logic returns to waiting for a mode code. Raising `cs_n_i` during a read also drops `sdat_oe_o` to 0.
- R2: Mode code 101 followed by six address bits (A5 first) and four data bits (D0 first) stores that nibble at the address.
- R3: After mode code 110 and an address, each read-strobe falling edge puts the next bit of the addressed nibble on `sdat_o`, D0 first.
- R4: The address moves up by one after each complete nibble, in both read and write, and it wraps from 63 to 0.
- R5: In mode 101, a read-strobe falling edge at the start of a nibble begins a read-modify-write. The block sends the four bits at the current address and then takes four bits that it stores at that same address. Only after that does the address advance.
- R6: Mode code 100 is followed by nine-bit codes (C8 first). Any number of codes may follow one mode code, and each recognised code gives exactly one single-cycle pulse on `cmd_stb_o`.
- R7: Strobe bits, with codes in C8..C0 order and x meaning don't care:
  - bit0: 0000_0000_x
  - bit1: 0000_0001_x
  - bit2: 0000_0010_x
  - bit3: 0000_0011_x
  - bit5: 010x_xxxx_x (high tone)
  - bit6: 0110_xxxx_x (low tone)
  - No other code produces a strobe, and at most one bit is set at a time.
- R8: Code 0010_abxc_x pulses bit4 and sets `cfg_commons_o` to ab (00, 01 and 10 select 2, 3 and 4 commons) and `cfg_bias_o` to c (0 for 1/2, 1 for 1/3). With ab = 11 the code has no effect.
- R9: `sdat_oe_o` is 1 only while read bits are being sent: in mode 110 after the first read-strobe fall, and in a read-modify-write from its first read fall until the next read or write strobe edge after the fourth bit. It stays 0 during writes, commands and idle.
- R10: A frame that ends before the last bit of a nibble or a command code changes neither the memory nor the configuration, and it raises no strobe.
- R11: After a mode code other than 110, 101 or 100, every further bit of the frame is ignored.
- R12: After reset, the memory reads 0 everywhere, `sdat_oe_o` and `cmd_stb_o` are 0, and `cfg_commons_o` and `cfg_bias_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Frame select, active low |
| wclk_i | input | 1 | Write strobe; data taken on its rising edge |
| rclk_i | input | 1 | Read strobe; data driven after its falling edge |
| sdat_i | input | 1 | Serial data from host |
| sdat_o | output | 1 | Serial read data to host |
| sdat_oe_o | output | 1 | Drive enable for the data line |
| cmd_stb_o | output | 7 | One-cycle command strobes, one-hot |
| cfg_commons_o | output | 2 | Selected common count code |
| cfg_bias_o | output | 1 | Selected bias (0 = 1/2, 1 = 1/3) |

## Verification
The bench targets four corner cases:
- Wraparound: it writes and reads nibbles that cross address 63. A design without the wrap would put the third nibble at 64 and read back the wrong data.
- Read-modify-write order: it reads each nibble before overwriting it. A design that advanced the address after the read half would store the new nibble one address too far on.
- Aborted and invalid frames: it raises select partway through a nibble and partway through a command, and it sends an invalid mode code followed by a valid-looking write. A design that committed early, or re-parsed the frame, would change memory that must stay intact.
- Command decoding: don't-care bits are set to 1 and a reserved layout code is sent. These expose a decoder that compares too many bits or accepts ab = 11.

// File: rtl/lcdsi_pkg.sv
package lcdsi_pkg;
  localparam int ID_W = 3;
  localparam logic [ID_W-1:0] ID_RD  = 3'b110;
  localparam logic [ID_W-1:0] ID_WR  = 3'b101;
  localparam logic [ID_W-1:0] ID_CMD = 3'b100;

  localparam int NUM_STB     = 7;
  localparam int STB_SYS_OFF = 0;
  localparam int STB_SYS_ON  = 1;
  localparam int STB_LCD_OFF = 2;
  localparam int STB_LCD_ON  = 3;
  localparam int STB_LAYOUT  = 4;
  localparam int STB_TONE_HI = 5;
  localparam int STB_TONE_LO = 6;

  typedef enum logic [2:0] {
    S_ID, S_ADDR, S_RD, S_WR, S_RMW_RD, S_RMW_WR, S_CMD, S_HALT
  } fr_state_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '1;
    else        pipe[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= '1;
      else        pipe[g] <= pipe[g-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/nibble_ram.sv
module nibble_ram #(
  parameter int ADDR_W = 6,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [NIB_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [NIB_W-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [NIB_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
  import lcdsi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NIB_W  = 4,
  parameter int CMD_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              bit_in,
  input  logic              wr_rise,
  input  logic              rd_fall,
  input  logic              rd_rise,
  input  logic [NIB_W-1:0]  rd_nib,
  output logic [ADDR_W-1:0] addr,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [NIB_W-1:0]  ram_wdata,
  output logic              sda_o,
  output logic              sda_oe,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_code
);
  localparam int MAXF   = (CMD_W > ADDR_W) ? CMD_W : ADDR_W;
  localparam int CNT_W  = $clog2(MAXF + 1);
  localparam int NIB_IW = (NIB_W > 1) ? $clog2(NIB_W) : 1;
  localparam logic [CNT_W-1:0] LAST_ID   = CNT_W'(ID_W - 1);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] LAST_NIB  = CNT_W'(NIB_W - 1);
  localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_W - 1);

  fr_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [ID_W-1:0]  id_sh;
  logic [CMD_W-1:0] cmd_sh;
  logic [NIB_W-1:0] nib;
  logic             rd_mode;
  logic [ID_W-1:0]  id_next;
  logic [NIB_IW-1:0] bidx;

  assign id_next = {id_sh[ID_W-2:0], bit_in};
  assign bidx    = cnt[NIB_IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_ID;
      cnt       <= '0;
      id_sh     <= '0;
      cmd_sh    <= '0;
      nib       <= '0;
      rd_mode   <= 1'b0;
      addr      <= '0;
      ram_we    <= 1'b0;
      ram_waddr <= '0;
      ram_wdata <= '0;
      sda_o     <= 1'b0;
      sda_oe    <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
    end else begin
      ram_we    <= 1'b0;
      cmd_valid <= 1'b0;
      if (!cs_act) begin
        state  <= S_ID;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          S_ID: if (wr_rise) begin
            id_sh <= id_next;
            if (cnt == LAST_ID) begin
              cnt <= '0;
              if (id_next == ID_RD) begin
                state <= S_ADDR; rd_mode <= 1'b1;
              end else if (id_next == ID_WR) begin
                state <= S_ADDR; rd_mode <= 1'b0;
              end else if (id_next == ID_CMD) begin
                state <= S_CMD;
              end else begin
                state <= S_HALT;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_ADDR: if (wr_rise) begin
            addr <= {addr[ADDR_W-2:0], bit_in};
            if (cnt == LAST_ADDR) begin
              cnt   <= '0;
              state <= rd_mode ? S_RD : S_WR;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_RD: if (rd_fall) begin
            sda_o  <= rd_nib[bidx];
            sda_oe <= 1'b1;
            if (cnt == LAST_NIB) begin
              cnt  <= '0;
              addr <= addr + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_WR: begin
            if (wr_rise) begin
              nib[bidx] <= bit_in;
              if (cnt == LAST_NIB) begin
                ram_we    <= 1'b1;
                ram_waddr <= addr;
                ram_wdata <= {bit_in, nib[NIB_W-2:0]};
                addr      <= addr + 1'b1;
                cnt       <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end else if (rd_fall && cnt == '0) begin
              sda_o  <= rd_nib[0];
              sda_oe <= 1'b1;
              cnt    <= 1;
              state  <= S_RMW_RD;
            end
          end
          S_RMW_RD: if (rd_fall) begin
            sda_o <= rd_nib[bidx];
            if (cnt == LAST_NIB) begin
              cnt   <= '0;
              state <= S_RMW_WR;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_RMW_WR: begin
            if (rd_rise) sda_oe <= 1'b0;
            if (wr_rise) begin
              sda_oe    <= 1'b0;
              nib[bidx] <= bit_in;
              if (cnt == LAST_NIB) begin
                ram_we    <= 1'b1;
                ram_waddr <= addr;
                ram_wdata <= {bit_in, nib[NIB_W-2:0]};
                addr      <= addr + 1'b1;
                cnt       <= '0;
                state     <= S_WR;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          S_CMD: if (wr_rise) begin
            cmd_sh <= {cmd_sh[CMD_W-2:0], bit_in};
            if (cnt == LAST_CMD) begin
              cmd_valid <= 1'b1;
              cmd_code  <= {cmd_sh[CMD_W-2:0], bit_in};
              cnt       <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (state == S_ID && !sda_oe));  // R1
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state inside {S_RD, S_RMW_RD, S_RMW_WR}));  // R9
  AST_FULL_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ($past(wr_rise) && $past(cnt) == LAST_NIB));  // R10
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_waddr == '1) |-> (addr == '0));  // R4
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import lcdsi_pkg::*;
#(
  parameter int CMD_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [CMD_W-1:0]   cmd_code,
  output logic [NUM_STB-1:0] cmd_stb,
  output logic [1:0]         cfg_commons,
  output logic               cfg_bias
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_stb     <= '0;
      cfg_commons <= 2'b00;
      cfg_bias    <= 1'b0;
    end else begin
      cmd_stb <= '0;
      if (cmd_valid) begin
        casez (cmd_code)
          9'b0000_0000_?: cmd_stb[STB_SYS_OFF] <= 1'b1;
          9'b0000_0001_?: cmd_stb[STB_SYS_ON]  <= 1'b1;
          9'b0000_0010_?: cmd_stb[STB_LCD_OFF] <= 1'b1;
          9'b0000_0011_?: cmd_stb[STB_LCD_ON]  <= 1'b1;
          9'b0010_????_?: if (cmd_code[4:3] != 2'b11) begin
            cmd_stb[STB_LAYOUT] <= 1'b1;
            cfg_commons         <= cmd_code[4:3];
            cfg_bias            <= cmd_code[1];
          end
          9'b010?_????_?: cmd_stb[STB_TONE_HI] <= 1'b1;
          9'b0110_????_?: cmd_stb[STB_TONE_LO] <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_stb));  // R7
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb != '0) |=> (cmd_stb == '0));  // R6
endmodule

// File: rtl/lcd_ser_front.sv
module lcd_ser_front
  import lcdsi_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int NIB_W       = 4,
  parameter int CMD_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n_i,
  input  logic               wclk_i,
  input  logic               rclk_i,
  input  logic               sdat_i,
  output logic               sdat_o,
  output logic               sdat_oe_o,
  output logic [NUM_STB-1:0] cmd_stb_o,
  output logic [1:0]         cfg_commons_o,
  output logic               cfg_bias_o
);
  logic [3:0] pins_s;
  logic cs_s, w_s, r_s, d_s;
  logic w_prev, r_prev;
  logic wr_rise, rd_fall, rd_rise;

  pin_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n_i, wclk_i, rclk_i, sdat_i}), .q(pins_s));

  assign {cs_s, w_s, r_s, d_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_prev <= 1'b1;
      r_prev <= 1'b1;
    end else begin
      w_prev <= w_s;
      r_prev <= r_s;
    end
  end

  assign wr_rise = w_s & ~w_prev;
  assign rd_fall = ~r_s & r_prev;
  assign rd_rise = r_s & ~r_prev;

  logic [ADDR_W-1:0] addr, waddr;
  logic [NIB_W-1:0]  rnib, wnib;
  logic              we, cvalid;
  logic [CMD_W-1:0]  ccode;

  frame_fsm #(.ADDR_W(ADDR_W), .NIB_W(NIB_W), .CMD_W(CMD_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_act(~cs_s), .bit_in(d_s),
    .wr_rise(wr_rise), .rd_fall(rd_fall), .rd_rise(rd_rise),
    .rd_nib(rnib), .addr(addr), .ram_we(we), .ram_waddr(waddr),
    .ram_wdata(wnib), .sda_o(sdat_o), .sda_oe(sdat_oe_o),
    .cmd_valid(cvalid), .cmd_code(ccode));

  nibble_ram #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wnib),
    .raddr(addr), .rdata(rnib));

  cmd_decode #(.CMD_W(CMD_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cvalid), .cmd_code(ccode),
    .cmd_stb(cmd_stb_o), .cfg_commons(cfg_commons_o), .cfg_bias(cfg_bias_o));
endmodule

// File: tb/test_lcd_ser_front.sv
module test_lcd_ser_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wclk = 1'b1, rclk = 1'b1, sdat = 1'b1;
  logic sdat_o, sdat_oe;
  logic [6:0] stb;
  logic [1:0] commons;
  logic bias;

  int errors = 0;
  int checks = 0;
  int stb_cnt [7];
  logic [3:0] mem [64];

  always #2 clk = ~clk;

  lcd_ser_front i_lcd_ser_front (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .wclk_i(wclk), .rclk_i(rclk),
    .sdat_i(sdat), .sdat_o(sdat_o), .sdat_oe_o(sdat_oe), .cmd_stb_o(stb),
    .cfg_commons_o(commons), .cfg_bias_o(bias));

  always @(negedge clk) begin
    for (int i = 0; i < 7; i++) if (stb[i]) stb_cnt[i]++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame;
    wait_n(2); cs_n = 1'b0; wait_n(6);
  endtask

  task automatic close_frame;
    wait_n(2); cs_n = 1'b1; wait_n(8);
  endtask

  task automatic pin_bit(input logic b);
    wait_n(1); sdat = b; wait_n(3);
    wclk = 1'b0; wait_n(6);
    wclk = 1'b1; wait_n(6);
  endtask

  task automatic get_bit(output logic b);
    wait_n(1); rclk = 1'b0; wait_n(8);
    b = sdat_o;
    rclk = 1'b1; wait_n(6);
  endtask

  task automatic send_msb(input logic [8:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) pin_bit(v[i]);
  endtask

  task automatic send_nib(input logic [3:0] v);
    for (int i = 0; i < 4; i++) pin_bit(v[i]);
  endtask

  task automatic recv_nib(output logic [3:0] v);
    logic b;
    for (int i = 0; i < 4; i++) begin get_bit(b); v[i] = b; end
  endtask

  task automatic read_run(input logic [5:0] a, input int n, input string req);
    logic [3:0] v;
    open_frame; send_msb(9'b110, 3); send_msb({3'b0, a}, 6);
    for (int k = 0; k < n; k++) begin
      recv_nib(v);
      chk(req, v, mem[6'(a + k)]);
    end
    chk("R9 oe during read", sdat_oe, 1);
    close_frame;
  endtask

  task automatic t_reset;
    chk("R12 oe", sdat_oe, 0);
    chk("R12 strobes", stb, 0);
    chk("R12 commons", commons, 0);
    chk("R12 bias", bias, 0);
    read_run(6'd63, 2, "R12 ram zero");
  endtask

  task automatic t_write_single;
    open_frame; send_msb(9'b101, 3); send_msb(9'd5, 6); send_nib(4'hA);
    chk("R9 oe in write", sdat_oe, 0);
    close_frame; mem[5] = 4'hA;
    read_run(6'd5, 1, "R2/R3 single nibble");
  endtask

  task automatic t_wrap;
    open_frame; send_msb(9'b101, 3); send_msb(9'd62, 6);
    send_nib(4'h1); send_nib(4'h2); send_nib(4'h3);
    close_frame; mem[62] = 4'h1; mem[63] = 4'h2; mem[0] = 4'h3;
    read_run(6'd62, 3, "R4 wrap");
  endtask

  task automatic t_rmw;
    logic [3:0] v;
    open_frame; send_msb(9'b101, 3); send_msb(9'd5, 6);
    recv_nib(v); chk("R5 rmw read", v, 4'hA);
    chk("R9 oe released after rmw read", sdat_oe, 0);
    send_nib(4'h3);
    recv_nib(v); chk("R5 rmw next addr", v, 4'h0);
    send_nib(4'h7);
    close_frame; mem[5] = 4'h3; mem[6] = 4'h7;
    read_run(6'd5, 2, "R5 rmw stored");
  endtask

  task automatic t_cmds;
    open_frame; send_msb(9'b100, 3);
    send_msb(9'b0000_0000_0, 9); wait_n(4);
    chk("R6 first strobe", stb_cnt[0], 1);
    chk("R6 no other", stb_cnt[1] + stb_cnt[2] + stb_cnt[3], 0);
    send_msb(9'b0000_0001_1, 9);
    send_msb(9'b0000_0010_0, 9);
    send_msb(9'b0000_0011_1, 9);
    send_msb(9'b0101_1010_1, 9);
    send_msb(9'b0110_0000_0, 9);
    send_msb(9'b0010_1001_0, 9);
    send_msb(9'b1110_0000_0, 9);
    send_msb(9'b0010_1100_0, 9);
    chk("R9 oe in command", sdat_oe, 0);
    close_frame;
    for (int i = 0; i < 7; i++) chk($sformatf("R7 strobe bit%0d", i), stb_cnt[i], 1);
    chk("R8 commons", commons, 2'b10);
    chk("R8 bias", bias, 1);
  endtask

  task automatic t_abort;
    logic b;
    open_frame; send_msb(9'b101, 3); send_msb(9'd10, 6);
    pin_bit(1'b1); pin_bit(1'b1);
    close_frame;
    read_run(6'd10, 1, "R10 partial nibble");
    open_frame; send_msb(9'b100, 3); send_msb(9'b0_0000, 5);
    close_frame;
    chk("R10 partial command", stb_cnt[0], 1);
    open_frame; send_msb(9'b110, 3); send_msb(9'd5, 6);
    get_bit(b);
    chk("R1 oe before select rise", sdat_oe, 1);
    close_frame;
    chk("R1 oe after select rise", sdat_oe, 0);
  endtask

  task automatic t_bad_id;
    open_frame; send_msb(9'b111, 3);
    send_msb(9'b101, 3); send_msb(9'd5, 6); send_nib(4'h0);
    send_msb(9'b0000_0001_0, 9);
    close_frame;
    chk("R11 no strobe", stb_cnt[1], 1);
    read_run(6'd5, 1, "R11 memory untouched");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 4'h0;
    for (int i = 0; i < 7; i++) stb_cnt[i] = 0;
    wait_n(5); rst_n = 1'b1; wait_n(5);
    t_reset;
    t_write_single;
    t_wrap;
    t_rmw;
    t_cmds;
    t_abort;
    t_bad_id;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule